// File: doc/BRIEF.md
# Interrupt Vector Dispatch Controller

This privileged, register-mapped unit lets a processor send an interrupt packet to another module. Software first loads three 64-bit outgoing data words. It then writes one trigger address. Bits of that address select the 5-bit target module. The controller copies the target and all three words into a held request for the interconnect. It waits for an acknowledge or a negative acknowledge, and reports its progress in a read-only status word.

The CPU side is a single-cycle access port. It carries an address space identifier, a 64-bit virtual address, a privilege flag, a write strobe and write data. Read data, a read-valid flag and two trap pulses return one cycle after the access.

Two states govern the transfer. In `S_IDLE` no request is outstanding. An accepted trigger write takes the transition *launch* (`S_IDLE`→`S_WAIT`). In `S_WAIT` the request is held. A response takes the transition *retire* (`S_WAIT`→`S_IDLE`). Any other input keeps the current state.

Top module: `intr_dispatch_ctrl`

## Requirements
- R1: After reset no request is outstanding (`req_valid`=0), the status word reads 0, every data word reads 0 and no trap is raised.
- R2: A privileged access in space 0x77 at VA 0x40, 0x50 or 0x60 writes or reads data word 0, 1 or 2. A read returns `rd_valid`=1 and the value on `rd_data` in the cycle after the access.
- R3: A privileged write in space 0x77 with VA[13:0]=0x70 and VA[63:19]=0 launches a dispatch when idle. From the next cycle `req_valid`=1, `req_target` equals VA[18:14], and `req_data` carries word i in bits [64*i+63:64*i].
- R4: The status word is read by a privileged read in space 0x48 at VA 0. Bit 0 is BUSY (a request is outstanding), bit 1 is NACK (the last dispatch was refused), and bits 63:2 read 0.
- R5: The request stays asserted and unchanged until `rsp_valid` is seen. In the cycle after the response, `req_valid` and BUSY are 0.
- R6: NACK becomes equal to `rsp_nack` when the response arrives. A launch clears NACK to 0.
- R7: Writes to the data words while BUSY is 1 update the words but not the packet in flight.
- R8: A trigger write while BUSY is 1 is dropped. The target, the data and the status are unchanged, and no second request follows the response.
- R9: A privileged read of the trigger address raises `trap_dax` and has no other effect.
- R10: Any non-privileged access in space 0x77 or 0x48 raises `trap_priv` and changes no register.
- R11: A privileged access to an unmapped VA in space 0x77 or 0x48 raises `trap_dax` and changes no register. A write to the status word also raises `trap_dax` and changes no register. A trigger address with any of VA[63:19] set counts as unmapped.
- R12: Each access produces at most one of `rd_valid`, `trap_priv` and `trap_dax`, as a one-cycle pulse. Accesses in any other address space are ignored: no pulse and no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | Access is privileged |
| acc_asi | input | 8 | Address space identifier |
| acc_va | input | 64 | Virtual address |
| acc_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid (cycle after access) |
| rd_data | output | 64 | Read data |
| trap_priv | output | 1 | Privileged-action trap pulse |
| trap_dax | output | 1 | Data-access-exception trap pulse |
| req_valid | output | 1 | Dispatch request outstanding |
| req_target | output | 5 | Target module ID |
| req_data | output | 192 | Three latched data words |
| rsp_valid | input | 1 | Interconnect response |
| rsp_nack | input | 1 | Response is a refusal |

## Verification
On every cycle the assertions check the following:
- A launch produces a request with the addressed target and a cleared NACK.
- A held request stays stable until a response arrives.
- A refusal sets NACK and ends BUSY.
- A trigger while busy leaves the packet alone.
- The three per-access result pulses never overlap.

The bench scenarios are the only way to show the rest:
- The address decode, including the unmapped and out-of-range addresses.
- That trapping accesses leave no trace in the registers read back later.
- The exact status values seen through reads.
- Full packet contents for all 32 targets under random response delays.

// File: rtl/idc_pkg.sv
package idc_pkg;
    localparam logic [7:0]  ASI_OUT      = 8'h77;
    localparam logic [7:0]  ASI_STAT     = 8'h48;
    localparam logic [13:0] VA_TRIGGER   = 14'h0070;
    localparam logic [63:0] VA_DATA_BASE = 64'h40;
    localparam logic [63:0] VA_DATA_STEP = 64'h10;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_DATA_RD,
        ACC_DATA_WR,
        ACC_LAUNCH,
        ACC_STATUS_RD,
        ACC_TRAP_PRIV,
        ACC_TRAP_DAX
    } acc_kind_e;

    typedef enum logic {
        S_IDLE,
        S_WAIT
    } dsp_state_e;
endpackage

// File: rtl/idc_decode.sv
module idc_decode
    import idc_pkg::*;
#(
    parameter int NUM_WORDS = 3,
    parameter int ID_W      = 5,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic             valid,
    input  logic             write,
    input  logic             priv,
    input  logic [7:0]       asi,
    input  logic [63:0]      va,
    output acc_kind_e        kind,
    output logic [IDX_W-1:0] word_idx,
    output logic [ID_W-1:0]  target
);
    logic [NUM_WORDS-1:0] hit;
    logic                 trig_hit;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_hit
        assign hit[i] = (va == VA_DATA_BASE + VA_DATA_STEP * 64'(i));
    end

    assign trig_hit = (va[13:0] == VA_TRIGGER) && (va[63:14+ID_W] == '0);
    assign target   = va[14 +: ID_W];

    always_comb begin
        word_idx = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (hit[i]) word_idx = IDX_W'(i);
        end
    end

    always_comb begin
        kind = ACC_NONE;
        if (valid && (asi == ASI_OUT || asi == ASI_STAT)) begin
            if (!priv) begin
                kind = ACC_TRAP_PRIV;
            end else if (asi == ASI_OUT) begin
                if (|hit)          kind = write ? ACC_DATA_WR : ACC_DATA_RD;
                else if (trig_hit) kind = write ? ACC_LAUNCH  : ACC_TRAP_DAX;
                else               kind = ACC_TRAP_DAX;
            end else begin
                kind = (va == '0 && !write) ? ACC_STATUS_RD : ACC_TRAP_DAX;
            end
        end
    end
endmodule

// File: rtl/idc_regs.sv
module idc_regs #(
    parameter int NUM_WORDS = 3,
    parameter int DATA_W    = 64,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_WORDS-1:0][DATA_W-1:0] words
);
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                                 words[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))      words[i] <= wdata;
        end
    end
endmodule

// File: rtl/idc_fsm.sv
module idc_fsm
    import idc_pkg::*;
#(
    parameter int NUM_WORDS = 3,
    parameter int DATA_W    = 64,
    parameter int ID_W      = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             launch,
    input  logic [ID_W-1:0]                  launch_target,
    input  logic [NUM_WORDS-1:0][DATA_W-1:0] words,
    input  logic                             rsp_valid,
    input  logic                             rsp_nack,
    output logic                             busy,
    output logic                             nack,
    output logic                             req_valid,
    output logic [ID_W-1:0]                  req_target,
    output logic [NUM_WORDS-1:0][DATA_W-1:0] req_words
);
    dsp_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (launch)    state_nx = S_WAIT;
            S_WAIT: if (rsp_valid) state_nx = S_IDLE;
            default:               state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nack       <= 1'b0;
            req_target <= '0;
            req_words  <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (launch) begin
                    nack       <= 1'b0;
                    req_target <= launch_target;
                    req_words  <= words;
                end
                S_WAIT: if (rsp_valid) nack <= rsp_nack;
                default: ;
            endcase
        end
    end

    assign busy      = (state == S_WAIT);
    assign req_valid = busy;

    a_r3_launch_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && launch) |=> (busy && !nack && req_target == $past(launch_target)));
    a_r5_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(req_target) && $stable(req_words)));
    a_r6_nack_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rsp_valid) |=> (!busy && nack == $past(rsp_nack)));
    a_r8_busy_launch_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && launch && !rsp_valid) |=> (busy && $stable(req_target) && $stable(nack)));
endmodule

// File: rtl/intr_dispatch_ctrl.sv
module intr_dispatch_ctrl
    import idc_pkg::*;
#(
    parameter int NUM_WORDS = 3,
    parameter int DATA_W    = 64,
    parameter int ID_W      = 5,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_valid,
    input  logic                        acc_write,
    input  logic                        acc_priv,
    input  logic [7:0]                  acc_asi,
    input  logic [63:0]                 acc_va,
    input  logic [DATA_W-1:0]           acc_wdata,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        trap_priv,
    output logic                        trap_dax,
    output logic                        req_valid,
    output logic [ID_W-1:0]             req_target,
    output logic [NUM_WORDS*DATA_W-1:0] req_data,
    input  logic                        rsp_valid,
    input  logic                        rsp_nack
);
    acc_kind_e                        kind;
    logic [IDX_W-1:0]                 word_idx;
    logic [ID_W-1:0]                  target;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;
    logic [NUM_WORDS-1:0][DATA_W-1:0] req_words;
    logic                             busy, nack;
    logic [DATA_W-1:0]                rd_mux;

    idc_decode #(.NUM_WORDS(NUM_WORDS), .ID_W(ID_W)) u_dec (
        .valid(acc_valid), .write(acc_write), .priv(acc_priv),
        .asi(acc_asi), .va(acc_va),
        .kind(kind), .word_idx(word_idx), .target(target)
    );

    idc_regs #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(kind == ACC_DATA_WR), .wr_idx(word_idx), .wdata(acc_wdata),
        .words(words)
    );

    idc_fsm #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W), .ID_W(ID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .launch(kind == ACC_LAUNCH), .launch_target(target), .words(words),
        .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
        .busy(busy), .nack(nack), .req_valid(req_valid),
        .req_target(req_target), .req_words(req_words)
    );

    assign req_data = req_words;

    always_comb begin
        rd_mux = '0;
        if (kind == ACC_DATA_RD && 32'(word_idx) < NUM_WORDS) rd_mux = words[word_idx];
        else if (kind == ACC_STATUS_RD) rd_mux = DATA_W'({nack, busy});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            trap_priv <= 1'b0;
            trap_dax  <= 1'b0;
        end else begin
            rd_valid  <= (kind == ACC_DATA_RD) || (kind == ACC_STATUS_RD);
            rd_data   <= rd_mux;
            trap_priv <= (kind == ACC_TRAP_PRIV);
            trap_dax  <= (kind == ACC_TRAP_DAX);
        end
    end

    a_r12_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_valid, trap_priv, trap_dax}) <= 1);
    a_r4_status_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_STATUS_RD) |=> (rd_valid && rd_data[DATA_W-1:2] == '0));
    a_r10_priv_trap_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_TRAP_PRIV && !busy) |=> !req_valid);
endmodule

// File: tb/sim_intr_dispatch_ctrl.sv
module sim_intr_dispatch_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0;
    logic [7:0]   acc_asi = '0;
    logic [63:0]  acc_va = '0, acc_wdata = '0;
    logic         rd_valid, trap_priv, trap_dax, req_valid;
    logic [63:0]  rd_data;
    logic [4:0]   req_target;
    logic [191:0] req_data;
    logic         rsp_valid = 1'b0, rsp_nack = 1'b0;

    int total = 0, fails = 0;
    logic         o_rdv, o_tp, o_td;
    logic [63:0]  o_rd;

    always #5 clk = ~clk;

    intr_dispatch_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_priv(acc_priv), .acc_asi(acc_asi), .acc_va(acc_va), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .trap_priv(trap_priv), .trap_dax(trap_dax),
        .req_valid(req_valid), .req_target(req_target), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_nack(rsp_nack)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic access(input logic wr, input logic pv, input logic [7:0] asi,
                          input logic [63:0] va, input logic [63:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_priv = pv;
        acc_asi = asi; acc_va = va; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
        o_rdv = rd_valid; o_rd = rd_data; o_tp = trap_priv; o_td = trap_dax;
    endtask

    function automatic logic [63:0] dva(input int i);
        return 64'h40 + 64'h10 * 64'(i);
    endfunction

    function automatic logic [63:0] pat(input int t, input int i);
        return {32'(t * 977 + 13), 32'hC0DE_0000 + 32'(i * 4099 + t)};
    endfunction

    function automatic logic [63:0] tva(input int t);
        return (64'(t) << 14) | 64'h70;
    endfunction

    // plain read-back of a data word, checked against expectation
    task automatic expect_word(input int i, input logic [63:0] exp, input string tag);
        access(1'b0, 1'b1, 8'h77, dva(i), '0);
        chk(o_rdv && o_rd == exp && !o_tp && !o_td, tag, o_rd, exp);
    endtask

    task automatic expect_status(input logic [63:0] exp, input string tag);
        access(1'b0, 1'b1, 8'h48, 64'h0, '0);
        chk(o_rdv && o_rd == exp, tag, o_rd, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!req_valid && !trap_priv && !trap_dax && !rd_valid, "R1 outputs idle", {60'b0, req_valid, trap_priv, trap_dax, rd_valid}, 64'h0);
        expect_status(64'h0, "R1 status zero");
        for (int i = 0; i < 3; i++) expect_word(i, 64'h0, "R1 data zero");

        // R2 data write/read
        for (int i = 0; i < 3; i++) access(1'b1, 1'b1, 8'h77, dva(i), 64'hFACE_0000_0000_0000 | 64'(i + 1));
        for (int i = 0; i < 3; i++) expect_word(i, 64'hFACE_0000_0000_0000 | 64'(i + 1), "R2 data readback");

        // R12 other address space ignored
        access(1'b1, 1'b0, 8'h20, dva(0), 64'h1234);
        chk(!o_rdv && !o_tp && !o_td, "R12 foreign space silent", {61'b0, o_rdv, o_tp, o_td}, 64'h0);
        access(1'b1, 1'b1, 8'h20, tva(3), 64'h0);
        chk(!req_valid && !o_td, "R12 foreign trigger ignored", {63'b0, req_valid}, 64'h0);
        expect_word(0, 64'hFACE_0000_0000_0001, "R12 foreign write no effect");

        // R9 read of trigger address
        access(1'b0, 1'b1, 8'h77, tva(5), '0);
        chk(o_td && !o_tp && !o_rdv && !req_valid, "R9 trigger read traps", {61'b0, o_td, o_rdv, req_valid}, 64'h4);

        // R10 non-privileged accesses
        access(1'b1, 1'b0, 8'h77, dva(1), 64'hDEAD);
        chk(o_tp && !o_td && !o_rdv, "R10 data write priv trap", {62'b0, o_tp, o_td}, 64'h2);
        expect_word(1, 64'hFACE_0000_0000_0002, "R10 data unchanged");
        access(1'b1, 1'b0, 8'h77, tva(7), '0);
        chk(o_tp && !req_valid, "R10 trigger priv trap no launch", {62'b0, o_tp, req_valid}, 64'h2);
        access(1'b0, 1'b0, 8'h48, 64'h0, '0);
        chk(o_tp && !o_rdv, "R10 status read priv trap", {62'b0, o_tp, o_rdv}, 64'h2);

        // R11 unmapped / read-only
        access(1'b1, 1'b1, 8'h77, 64'h48, 64'hBAD);
        chk(o_td && !o_tp, "R11 unmapped data VA", {62'b0, o_td, o_tp}, 64'h2);
        for (int i = 0; i < 3; i++) expect_word(i, 64'hFACE_0000_0000_0000 | 64'(i + 1), "R11 data unchanged");
        access(1'b1, 1'b1, 8'h48, 64'h0, 64'h3);
        chk(o_td, "R11 status write traps", {63'b0, o_td}, 64'h1);
        expect_status(64'h0, "R11 status unchanged");
        access(1'b1, 1'b1, 8'h77, tva(2) | (64'h1 << 20), '0);
        chk(o_td && !req_valid, "R11 trigger high VA bit", {62'b0, o_td, req_valid}, 64'h2);
        access(1'b0, 1'b1, 8'h48, 64'h8, '0);
        chk(o_td && !o_rdv, "R11 status bad VA", {62'b0, o_td, o_rdv}, 64'h2);

        // sweep every target with random response delays
        for (int t = 0; t < 32; t++) begin
            logic exp_nack;
            logic [4:0] exp_tgt;
            logic [191:0] exp_pkt;
            exp_nack = (t % 3 == 0);
            exp_tgt  = 5'(t);
            for (int i = 0; i < 3; i++) access(1'b1, 1'b1, 8'h77, dva(i), pat(t, i));
            exp_pkt = {pat(t, 2), pat(t, 1), pat(t, 0)};
            access(1'b1, 1'b1, 8'h77, tva(t), '0);
            chk(req_valid && !o_td && !o_tp, "R3 request raised", {63'b0, req_valid}, 64'h1);
            chk(req_target == exp_tgt, "R3 target", 64'(req_target), 64'(exp_tgt));
            for (int i = 0; i < 3; i++)
                chk(req_data[64*i +: 64] == exp_pkt[64*i +: 64], "R3 packet word", req_data[64*i +: 64], exp_pkt[64*i +: 64]);
            expect_status(64'h1, "R4 R6 busy with nack cleared");
            if (t % 4 == 1) begin
                access(1'b1, 1'b1, 8'h77, dva(0), 64'h5555_AAAA_0000_0000 | 64'(t));
                chk(req_data[63:0] == exp_pkt[63:0], "R7 packet unchanged", req_data[63:0], exp_pkt[63:0]);
                expect_word(0, 64'h5555_AAAA_0000_0000 | 64'(t), "R7 register updated");
            end
            if (t % 4 == 2) begin
                access(1'b1, 1'b1, 8'h77, tva((t + 9) % 32), '0);
                chk(req_valid && req_target == exp_tgt, "R8 busy trigger dropped", 64'(req_target), 64'(exp_tgt));
                expect_status(64'h1, "R8 status unchanged");
            end
            begin
                int dly;
                dly = int'($urandom_range(0, 5));
                for (int d = 0; d < dly; d++) begin
                    @(negedge clk);
                    chk(req_valid && req_target == exp_tgt && req_data == exp_pkt, "R5 held while waiting", 64'(req_target), 64'(exp_tgt));
                end
            end
            @(negedge clk);
            rsp_valid = 1'b1; rsp_nack = exp_nack;
            @(negedge clk);
            rsp_valid = 1'b0; rsp_nack = 1'b0;
            chk(!req_valid, "R5 request retired", {63'b0, req_valid}, 64'h0);
            @(negedge clk);
            chk(!req_valid, "R8 no second request", {63'b0, req_valid}, 64'h0);
            expect_status({62'b0, exp_nack, 1'b0}, "R6 status after response");
        end

        // R6 stray response while idle is ignored; NACK kept
        @(negedge clk); rsp_valid = 1'b1; rsp_nack = 1'b0;
        @(negedge clk); rsp_valid = 1'b0;
        chk(!req_valid, "R6 idle response no request", {63'b0, req_valid}, 64'h0);

        summary();
        $finish;
    end
endmodule